// File: doc/BRIEF.md
# Decode-Stage Data-Hazard Stall Unit

This block is the stall decision logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The pipeline forwards results and compares conditional branch operands in decode. In each cycle the block looks at the register sources of the instruction in decode and at the destinations of the instructions in execute and memory. From these it decides whether decode must wait this cycle. When it holds, the fetch address and the fetch/decode register are frozen, and the control word entering execute is replaced by a bubble.

Three producer/consumer pairs need a wait even with forwarding:

- A load result needed by any instruction in the very next slot.
- An ALU result needed by the branch that follows it.
- A load result needed by the branch that follows it. This case costs two cycles.

The logic is purely combinational and has no counter. The two-cycle case arises because the rule is evaluated again once the load has moved from execute to memory. A parameter selects whether branches resolve in decode. When they resolve later, only the load case remains.

Top module: `hazard_stall_unit`

## Requirements
- R1: When execute holds a load (`ex_mem_read`=1) whose nonzero `ex_rd` equals a source used by a non-branch instruction in decode, exactly one hold cycle is produced for that pair.
- R2: When execute holds a register-writing non-load (`ex_reg_write`=1, `ex_mem_read`=0) whose nonzero `ex_rd` equals a source used by a branch in decode (`id_is_branch`=1), exactly one hold cycle is produced.
- R3: A load directly followed by a branch that reads its nonzero destination produces exactly two hold cycles. The first occurs while the load is in execute and the second while it is in memory. A load in memory (`mem_mem_read`=1) that matches a branch source holds by itself.
- R4: Forwarding covers all other cases with no hold. These include an ALU result feeding a non-branch consumer, a load in memory feeding a non-branch consumer, and a load feeding an instruction that does not read its destination.
- R5: A destination of register 0 never produces a hold.
- R6: A source whose use flag (`id_use_rs1` / `id_use_rs2`) is 0 never takes part in a match, whatever its field value.
- R7: While holding, `stall`=1, `pc_write`=0, `ifid_write`=0 and `idex_flush`=1. Otherwise `stall`=0, `pc_write`=1, `ifid_write`=1 and `idex_flush`=0.
- R8: With no register writer in execute (`ex_reg_write`=0, `ex_mem_read`=0) and no load in memory, there is no hold. The idle state (all inputs 0) gives `stall`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| stall | output | 1 | Decode holds this cycle |
| pc_write | output | 1 | Fetch address may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| idex_flush | output | 1 | Zero the control word entering execute |

## Verification
The block holds no state, so a wrong decision appears at the ports in the same cycle the offending pair sits in decode and execute. It shows as a changed count of hold cycles before the consumer leaves decode. A missing match gives too few holds, which silently corrupts data in the real pipeline. A spurious match, such as one on register 0 or on an unused source field, gives an extra hold. A broken memory-stage rule changes the load-to-branch count from two to one. The bench therefore models the pipeline advance around the block and compares the total hold count of each producer/consumer pair. It also checks that the four outputs agree in every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [2:0] {
      HZ_NONE       = 3'd0,
      HZ_LOAD_USE   = 3'd1,
      HZ_ALU_BRANCH = 3'd2,
      HZ_LOAD_BR_EX = 3'd3,
      HZ_LOAD_BR_MM = 3'd4
   } hz_cause_e;

   localparam int unsigned HZ_NUM_SRC = 2;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic              src_used,
   input  logic [REG_AW-1:0] dst,
   input  logic              dst_live,
   output logic              hit
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   always_comb begin
      hit = src_used && dst_live && (dst != ZERO_REG) && (src == dst);
   end
endmodule

// File: rtl/hz_stall_rules.sv
module hz_stall_rules
   import hz_pkg::*;
#(
   parameter bit BRANCH_IN_ID = 1'b1
) (
   input  logic      is_branch,
   input  logic      ex_load,
   input  logic      ex_alu_wr,
   input  logic      ex_hit,
   input  logic      mem_load,
   input  logic      mem_hit,
   output hz_cause_e cause
);
   generate
      if (BRANCH_IN_ID) begin : g_br_id
         always_comb begin
            if (ex_load && ex_hit)
               cause = is_branch ? HZ_LOAD_BR_EX : HZ_LOAD_USE;
            else if (is_branch && ex_alu_wr && ex_hit)
               cause = HZ_ALU_BRANCH;
            else if (is_branch && mem_load && mem_hit)
               cause = HZ_LOAD_BR_MM;
            else
               cause = HZ_NONE;
         end
      end else begin : g_br_ex
         logic unused_br;
         assign unused_br = is_branch ^ ex_alu_wr ^ mem_load ^ mem_hit;
         always_comb begin
            if (ex_load && ex_hit)
               cause = HZ_LOAD_USE;
            else
               cause = HZ_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW       = 5,
   parameter bit          BRANCH_IN_ID = 1'b1
) (
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use_rs1,
   input  logic              id_use_rs2,
   input  logic              id_is_branch,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_reg_write,
   input  logic              ex_mem_read,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_mem_read,
   output logic              stall,
   output logic              pc_write,
   output logic              ifid_write,
   output logic              idex_flush
);
   localparam int unsigned NSRC = HZ_NUM_SRC;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hazard_stall_unit: REG_AW out of range");
      end
   endgenerate

   logic [REG_AW-1:0] src_f [NSRC];
   logic [NSRC-1:0]   src_u;
   logic [NSRC-1:0]   ex_hit_v;
   logic [NSRC-1:0]   mem_hit_v;
   logic              ex_live;
   logic              ex_alu_wr;
   hz_cause_e         cause;

   assign src_f[0]  = id_rs1;
   assign src_f[1]  = id_rs2;
   assign src_u     = {id_use_rs2, id_use_rs1};
   assign ex_live   = ex_reg_write | ex_mem_read;
   assign ex_alu_wr = ex_reg_write & ~ex_mem_read;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         hz_src_match #(.REG_AW(REG_AW)) u_ex_cmp (
            .src      (src_f[s]),
            .src_used (src_u[s]),
            .dst      (ex_rd),
            .dst_live (ex_live),
            .hit      (ex_hit_v[s])
         );
         hz_src_match #(.REG_AW(REG_AW)) u_mem_cmp (
            .src      (src_f[s]),
            .src_used (src_u[s]),
            .dst      (mem_rd),
            .dst_live (mem_mem_read),
            .hit      (mem_hit_v[s])
         );
      end
   endgenerate

   hz_stall_rules #(.BRANCH_IN_ID(BRANCH_IN_ID)) u_rules (
      .is_branch (id_is_branch),
      .ex_load   (ex_mem_read),
      .ex_alu_wr (ex_alu_wr),
      .ex_hit    (|ex_hit_v),
      .mem_load  (mem_mem_read),
      .mem_hit   (|mem_hit_v),
      .cause     (cause)
   );

   always_comb begin
      stall      = (cause != HZ_NONE);
      pc_write   = ~stall;
      ifid_write = ~stall;
      idex_flush = stall;
   end
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
   parameter int unsigned REG_AW = 5
) (
   input logic [REG_AW-1:0] id_rs1,
   input logic [REG_AW-1:0] id_rs2,
   input logic              id_use_rs1,
   input logic              id_use_rs2,
   input logic              id_is_branch,
   input logic [REG_AW-1:0] ex_rd,
   input logic              ex_reg_write,
   input logic              ex_mem_read,
   input logic [REG_AW-1:0] mem_rd,
   input logic              mem_mem_read,
   input logic              stall,
   input logic              pc_write,
   input logic              ifid_write,
   input logic              idex_flush
);
   logic unused_chk;
   assign unused_chk = id_is_branch ^ ex_reg_write ^ (|id_rs2);

   always_comb begin
      AST_FREEZE_PAIR: assert (pc_write == ifid_write); // R7
      AST_BUBBLE_ON_HOLD: assert (idex_flush == ~pc_write && stall == idex_flush); // R7
      if (ex_rd == '0 && (mem_rd == '0 || !mem_mem_read))
         AST_ZERO_DEST_QUIET: assert (!stall); // R5
      if (!id_use_rs1 && !id_use_rs2)
         AST_UNUSED_SRC_QUIET: assert (!stall); // R6
      if (!ex_reg_write && !ex_mem_read && !mem_mem_read)
         AST_NO_WRITER_QUIET: assert (!stall); // R8
      if (ex_mem_read && ex_rd != '0 && id_use_rs1 && id_rs1 == ex_rd)
         AST_LOAD_USE_HOLD: assert (stall); // R1
   end
endmodule

bind hazard_stall_unit hz_stall_chk #(.REG_AW(REG_AW)) u_chk (
   .id_rs1       (id_rs1),
   .id_rs2       (id_rs2),
   .id_use_rs1   (id_use_rs1),
   .id_use_rs2   (id_use_rs2),
   .id_is_branch (id_is_branch),
   .ex_rd        (ex_rd),
   .ex_reg_write (ex_reg_write),
   .ex_mem_read  (ex_mem_read),
   .mem_rd       (mem_rd),
   .mem_mem_read (mem_mem_read),
   .stall        (stall),
   .pc_write     (pc_write),
   .ifid_write   (ifid_write),
   .idex_flush   (idex_flush)
);

// File: tb/sim_hazard_stall_unit.sv
`timescale 1ns/1ps
module sim_hazard_stall_unit;
   localparam int AW = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
   logic id_use_rs1 = 0, id_use_rs2 = 0, id_is_branch = 0;
   logic ex_reg_write = 0, ex_mem_read = 0, mem_mem_read = 0;
   logic stall, pc_write, ifid_write, idex_flush;

   hazard_stall_unit #(.REG_AW(AW)) u0 (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
      .id_use_rs2(id_use_rs2), .id_is_branch(id_is_branch),
      .ex_rd(ex_rd), .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
      .mem_rd(mem_rd), .mem_mem_read(mem_mem_read),
      .stall(stall), .pc_write(pc_write), .ifid_write(ifid_write),
      .idex_flush(idex_flush));

   int n_cmp = 0, n_bad = 0;
   bit done_flag = 0;
   int exp_q[$];
   string tag_q[$];
   int hold_cnt = 0;
   bit seq_on = 0;
   event seq_done;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: counts hold cycles at each edge, compares on sequence end
   always @(posedge clk) if (seq_on && stall) hold_cnt++;
   always @(seq_done) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(hold_cnt == e, t, hold_cnt, e);
      hold_cnt = 0;
   end

   task automatic check_outs(input string tag);
      check(pc_write == ~stall && ifid_write == ~stall && idex_flush == stall,
            {"R7 ", tag}, {pc_write, ifid_write, idex_flush}, {~stall, ~stall, stall});
   endtask

   // driver: producer enters execute while consumer sits in decode
   task automatic run_pair(input string tag, input bit p_ld, input bit p_wr,
                           input int p_rd, input bit c_br, input int c1, input bit u1,
                           input int c2, input bit u2, input int exp_holds);
      bit e_ld, e_wr, m_ld, held;
      logic [AW-1:0] e_rd, m_rd;
      exp_q.push_back(exp_holds);
      tag_q.push_back(tag);
      e_ld = p_ld; e_wr = p_wr; e_rd = AW'(p_rd);
      m_ld = 0; m_rd = '0;
      seq_on = 1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         id_rs1 = AW'(c1); id_rs2 = AW'(c2); id_use_rs1 = u1; id_use_rs2 = u2;
         id_is_branch = c_br;
         ex_rd = e_rd; ex_reg_write = e_wr; ex_mem_read = e_ld;
         mem_rd = m_rd; mem_mem_read = m_ld;
         #2;
         check_outs(tag);
         held = stall;
         @(posedge clk);
         #1;
         if (!held) break;
         m_ld = e_ld; m_rd = e_rd;
         e_ld = 0; e_wr = 0; e_rd = '0;
      end
      seq_on = 0;
      -> seq_done;
      @(negedge clk);
      id_use_rs1 = 0; id_use_rs2 = 0; id_is_branch = 0;
      ex_reg_write = 0; ex_mem_read = 0; mem_mem_read = 0;
      ex_rd = '0; mem_rd = '0; id_rs1 = '0; id_rs2 = '0;
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      check(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      @(negedge clk); #2;
      check(stall == 0, "R8 idle state", stall, 0);
      check_outs("idle");

      run_pair("R1 load->alu rs1", 1, 1, 5, 0, 5, 1, 0, 0, 1);
      run_pair("R1 load->alu rs2", 1, 1, 5, 0, 2, 1, 5, 1, 1);
      run_pair("R2 alu->branch rs1", 0, 1, 7, 1, 7, 1, 3, 1, 1);
      run_pair("R2 alu->branch rs2", 0, 1, 12, 1, 1, 1, 12, 1, 1);
      run_pair("R3 load->branch", 1, 1, 9, 1, 4, 1, 9, 1, 2);
      run_pair("R3 load->branch both srcs", 1, 1, 31, 1, 31, 1, 31, 1, 2);
      run_pair("R4 alu->alu forwarded", 0, 1, 7, 0, 7, 1, 7, 1, 0);
      run_pair("R4 load->unrelated branch", 1, 1, 3, 1, 4, 1, 6, 1, 0);
      run_pair("R5 load x0->alu", 1, 1, 0, 0, 0, 1, 0, 1, 0);
      run_pair("R5 load x0->branch", 1, 1, 0, 1, 0, 1, 0, 1, 0);
      run_pair("R5 alu x0->branch", 0, 1, 0, 1, 0, 1, 0, 1, 0);
      run_pair("R6 unused rs1", 1, 1, 5, 0, 5, 0, 8, 1, 0);
      run_pair("R6 unused rs2 branch", 0, 1, 6, 1, 2, 1, 6, 0, 0);
      run_pair("R8 non-writer->branch", 0, 0, 5, 1, 5, 1, 5, 1, 0);

      // memory-stage load with one instruction between producer and consumer
      @(negedge clk);
      mem_mem_read = 1; mem_rd = 5'd11; id_rs1 = 5'd11; id_use_rs1 = 1;
      id_is_branch = 0; #2;
      check(stall == 0, "R4 load in mem -> alu", stall, 0);
      @(negedge clk);
      id_is_branch = 1; #2;
      check(stall == 1, "R3 load in mem -> branch", stall, 1);
      check_outs("mem hold");
      @(negedge clk);
      mem_rd = 5'd0; id_rs1 = 5'd0; #2;
      check(stall == 0, "R5 load x0 in mem -> branch", stall, 0);
      @(negedge clk);
      mem_mem_read = 0; id_use_rs1 = 0; id_is_branch = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule